// File: doc/BRIEF.md
# Serial Port FIFO Level Flags and DMA Request Generator

This block sits beside the transmit and receive FIFOs of a serial port controller and turns their fill levels into the status and service signals that the rest of the chip needs. Each cycle it compares the two byte counts against fixed fractions of the FIFO depth, which gives the full, three-quarter, room and non-empty flags. It also compares them against four programmable thresholds taken from a single 32-bit DMA control word, which gives a request strobe and a panic strobe for each direction of an external DMA engine.

On the transmit side, the request and panic strobes fire when the level has fallen to or below the threshold, so the engine refills the FIFO. On the receive side, they fire when the level has risen strictly above the threshold, so the engine drains it. The receive request is also raised when the transfer has completed and bytes remain in the FIFO, so the tail of the data is collected. A single interrupt line combines the receive-needs-reading condition and the done condition, each under its own enable. Every output is registered.

Top module: `spi_fifo_flags`

## Requirements
- R1: `tx_dreq_o` is 1 when DMA is enabled and `tx_level_i` is less than or equal to the TX request threshold, which is bits 7:0 of `dma_ctrl_i`.
- R2: `tx_panic_o` is 1 when DMA is enabled and `tx_level_i` is less than or equal to the TX panic threshold, which is bits 15:8 of `dma_ctrl_i`.
- R3: `rx_dreq_o` is 1 when DMA is enabled and either of two conditions holds: `rx_level_i` is strictly greater than the RX request threshold (bits 23:16 of `dma_ctrl_i`), or `xfer_done_i` is 1 and `rx_level_i` is nonzero.
- R4: `rx_panic_o` is 1 when DMA is enabled and `rx_level_i` is strictly greater than the RX panic threshold, which is bits 31:24 of `dma_ctrl_i`.
- R5: `rx_need_read_o` is 1 when `rx_level_i` is at least three quarters of the depth (48 of 64) and `xfer_active_i` is 1. While `xfer_active_i` is 0 it is 0, whatever the level.
- R6: `tx_room_o` is 1 when `tx_level_i` is below the depth (64). It is 1 out of reset.
- R7: `rx_avail_o` is 1 when `rx_level_i` is nonzero. `rx_full_o` is 1 when `rx_level_i` equals the depth (64).
- R8: `irq_o` is 1 when `irq_rx_en_i` is 1 and the receive-needs-reading condition holds. It is also 1 when `irq_done_en_i` is 1 and `xfer_done_i` is 1.
- R9: Every output reflects the inputs sampled at the previous rising clock edge. While `rst_ni` is low, every output is 0 except `tx_room_o`, which is 1.
- R10: While `dma_en_i` is 0, `tx_dreq_o`, `tx_panic_o`, `rx_dreq_o` and `rx_panic_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_level_i | input | 7 | TX FIFO fill level in bytes |
| rx_level_i | input | 7 | RX FIFO fill level in bytes |
| xfer_active_i | input | 1 | Transfer active |
| xfer_done_i | input | 1 | Transfer complete |
| dma_en_i | input | 1 | DMA mode enable |
| irq_rx_en_i | input | 1 | Interrupt enable for the RX-needs-reading condition |
| irq_done_en_i | input | 1 | Interrupt enable for the done condition |
| dma_ctrl_i | input | 32 | Thresholds: RX panic 31:24, RX request 23:16, TX panic 15:8, TX request 7:0 |
| rx_full_o | output | 1 | RX FIFO full |
| rx_need_read_o | output | 1 | RX FIFO at least three quarters full during a transfer |
| tx_room_o | output | 1 | TX FIFO can accept a byte |
| rx_avail_o | output | 1 | RX FIFO holds data |
| tx_dreq_o | output | 1 | TX DMA request |
| tx_panic_o | output | 1 | TX DMA panic |
| rx_dreq_o | output | 1 | RX DMA request |
| rx_panic_o | output | 1 | RX DMA panic |
| irq_o | output | 1 | Interrupt |

## Verification
Assertions watch several relations on every cycle: the DMA strobes stay silent while DMA is off, a full FIFO also reports data, the needs-reading flag only follows an active transfer, and the end-of-transfer drain always raises the RX request. Some behaviour only the bench scenarios can show. These are the exact threshold edges in both comparison senses, the extreme threshold values 0x00 and 0xFF, the way the interrupt enables combine, and the one-cycle output latency. The bench sweeps every level from 0 to 64 under several threshold words and checks each output bit against its own rule.

// File: rtl/spi_flag_pkg.sv
`timescale 1ns/1ps
package spi_flag_pkg;

  typedef struct packed {
    logic [7:0] rx_panic;
    logic [7:0] rx_req;
    logic [7:0] tx_panic;
    logic [7:0] tx_req;
  } dma_thr_t;

  typedef enum logic {
    CMP_LE = 1'b0,
    CMP_GT = 1'b1
  } cmp_sense_e;

endpackage

// File: rtl/thr_cmp.sv
`timescale 1ns/1ps
module thr_cmp
  import spi_flag_pkg::*;
#(
  parameter int         LVL_W = 7,
  parameter int         THR_W = 8,
  parameter cmp_sense_e SENSE = CMP_LE
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             hit_o
);
  localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

  logic [CMP_W-1:0] lvl_x, thr_x;
  assign lvl_x = CMP_W'(level_i);
  assign thr_x = CMP_W'(thr_i);

  generate
    if (SENSE == CMP_LE) begin : g_le
      assign hit_o = (lvl_x <= thr_x);
    end else begin : g_gt
      assign hit_o = (lvl_x > thr_x);
    end
  endgenerate

endmodule

// File: rtl/tx_flag_unit.sv
`timescale 1ns/1ps
module tx_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int THR_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic             dma_en_i,
  input  logic [THR_W-1:0] thr_req_i,
  input  logic [THR_W-1:0] thr_panic_i,
  output logic             room_o,
  output logic             dreq_o,
  output logic             panic_o
);
  logic req_hit, panic_hit;

  thr_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .SENSE(CMP_LE)) u_req_cmp (
    .level_i(level_i), .thr_i(thr_req_i), .hit_o(req_hit)
  );
  thr_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .SENSE(CMP_LE)) u_panic_cmp (
    .level_i(level_i), .thr_i(thr_panic_i), .hit_o(panic_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      room_o  <= 1'b1;
      dreq_o  <= 1'b0;
      panic_o <= 1'b0;
    end else begin
      room_o  <= (level_i < LVL_W'(DEPTH));
      dreq_o  <= dma_en_i & req_hit;
      panic_o <= dma_en_i & panic_hit;
    end
  end

  p_room_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(level_i) < LVL_W'(DEPTH))) |-> room_o);

  p_req_le_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(dma_en_i) && ({1'b0, $past(level_i)} <= (LVL_W+1)'($past(thr_req_i))))
    |-> dreq_o);

endmodule

// File: rtl/rx_flag_unit.sv
`timescale 1ns/1ps
module rx_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int THR_W = 8,
  localparam int LVL_W    = $clog2(DEPTH + 1),
  localparam int NEED_LVL = (DEPTH * 3) / 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic             active_i,
  input  logic             done_i,
  input  logic             dma_en_i,
  input  logic [THR_W-1:0] thr_req_i,
  input  logic [THR_W-1:0] thr_panic_i,
  output logic             need_next_o,
  output logic             full_o,
  output logic             need_read_o,
  output logic             avail_o,
  output logic             dreq_o,
  output logic             panic_o
);
  logic req_hit, panic_hit, nonempty, drain;

  thr_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .SENSE(CMP_GT)) u_req_cmp (
    .level_i(level_i), .thr_i(thr_req_i), .hit_o(req_hit)
  );
  thr_cmp #(.LVL_W(LVL_W), .THR_W(THR_W), .SENSE(CMP_GT)) u_panic_cmp (
    .level_i(level_i), .thr_i(thr_panic_i), .hit_o(panic_hit)
  );

  assign nonempty    = (level_i != '0);
  assign drain       = done_i & nonempty;   // collect residual bytes after the end
  assign need_next_o = active_i & (level_i >= LVL_W'(NEED_LVL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o      <= 1'b0;
      need_read_o <= 1'b0;
      avail_o     <= 1'b0;
      dreq_o      <= 1'b0;
      panic_o     <= 1'b0;
    end else begin
      full_o      <= (level_i >= LVL_W'(DEPTH));
      need_read_o <= need_next_o;
      avail_o     <= nonempty;
      dreq_o      <= dma_en_i & (req_hit | drain);
      panic_o     <= dma_en_i & panic_hit;
    end
  end

  p_full_has_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> avail_o);

  p_need_only_active_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    need_read_o |-> $past(active_i));

  p_drain_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(dma_en_i) && $past(done_i) && ($past(level_i) != '0))
    |-> dreq_o);

endmodule

// File: rtl/spi_fifo_flags.sv
`timescale 1ns/1ps
module spi_fifo_flags
  import spi_flag_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             xfer_active_i,
  input  logic             xfer_done_i,
  input  logic             dma_en_i,
  input  logic             irq_rx_en_i,
  input  logic             irq_done_en_i,
  input  logic [31:0]      dma_ctrl_i,
  output logic             rx_full_o,
  output logic             rx_need_read_o,
  output logic             tx_room_o,
  output logic             rx_avail_o,
  output logic             tx_dreq_o,
  output logic             tx_panic_o,
  output logic             rx_dreq_o,
  output logic             rx_panic_o,
  output logic             irq_o
);
  dma_thr_t thr;
  logic     rx_need_next;

  assign thr = dma_thr_t'(dma_ctrl_i);

  tx_flag_unit #(.DEPTH(DEPTH), .THR_W(8)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (tx_level_i),
    .dma_en_i   (dma_en_i),
    .thr_req_i  (thr.tx_req),
    .thr_panic_i(thr.tx_panic),
    .room_o     (tx_room_o),
    .dreq_o     (tx_dreq_o),
    .panic_o    (tx_panic_o)
  );

  rx_flag_unit #(.DEPTH(DEPTH), .THR_W(8)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (rx_level_i),
    .active_i   (xfer_active_i),
    .done_i     (xfer_done_i),
    .dma_en_i   (dma_en_i),
    .thr_req_i  (thr.rx_req),
    .thr_panic_i(thr.rx_panic),
    .need_next_o(rx_need_next),
    .full_o     (rx_full_o),
    .need_read_o(rx_need_read_o),
    .avail_o    (rx_avail_o),
    .dreq_o     (rx_dreq_o),
    .panic_o    (rx_panic_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= (irq_rx_en_i & rx_need_next) | (irq_done_en_i & xfer_done_i);
  end

  p_dma_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(dma_en_i) |-> !(tx_dreq_o | tx_panic_o | rx_dreq_o | rx_panic_o));

  p_irq_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(irq_done_en_i) && $past(xfer_done_i)) |-> irq_o);

  p_irq_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(irq_done_en_i) && !$past(irq_rx_en_i)) |-> !irq_o);

endmodule

// File: tb/spi_fifo_flags_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_flags_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] tx_lvl = '0, rx_lvl = '0;
  logic       act = 1'b0, done = 1'b0, dma = 1'b0, ie_rx = 1'b0, ie_done = 1'b0;
  logic [31:0] ctrl = 32'h3020_1020;
  logic rx_full, rx_need, tx_room, rx_avail, tx_dreq, tx_panic, rx_dreq, rx_panic, irq;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];

  always #10 clk = ~clk;

  spi_fifo_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_level_i(tx_lvl), .rx_level_i(rx_lvl),
    .xfer_active_i(act), .xfer_done_i(done), .dma_en_i(dma),
    .irq_rx_en_i(ie_rx), .irq_done_en_i(ie_done), .dma_ctrl_i(ctrl),
    .rx_full_o(rx_full), .rx_need_read_o(rx_need), .tx_room_o(tx_room),
    .rx_avail_o(rx_avail), .tx_dreq_o(tx_dreq), .tx_panic_o(tx_panic),
    .rx_dreq_o(rx_dreq), .rx_panic_o(rx_panic), .irq_o(irq)
  );

  // bit order: 8 rx_full, 7 rx_need, 6 tx_room, 5 rx_avail, 4 tx_dreq,
  //            3 tx_panic, 2 rx_dreq, 1 rx_panic, 0 irq
  function automatic string req_of(int b);
    case (b)
      8: return "R7 rx_full";
      7: return "R5 rx_need_read";
      6: return "R6 tx_room";
      5: return "R7 rx_avail";
      4: return "R1 tx_dreq";
      3: return "R2 tx_panic";
      2: return "R3 rx_dreq";
      1: return "R4 rx_panic";
      default: return "R8 irq";
    endcase
  endfunction

  function automatic logic [8:0] model();
    logic [8:0] e;
    logic need;
    need = act && (rx_lvl >= 7'd48);
    e[8] = (rx_lvl == 7'd64);
    e[7] = need;
    e[6] = (tx_lvl < 7'd64);
    e[5] = (rx_lvl != 0);
    e[4] = dma && ({1'b0, tx_lvl} <= ctrl[7:0]);
    e[3] = dma && ({1'b0, tx_lvl} <= ctrl[15:8]);
    e[2] = dma && (({1'b0, rx_lvl} > ctrl[23:16]) || (done && rx_lvl != 0));
    e[1] = dma && ({1'b0, rx_lvl} > ctrl[31:24]);
    e[0] = (ie_rx && need) || (ie_done && done);
    return e;
  endfunction

  function automatic logic [8:0] outs();
    return {rx_full, rx_need, tx_room, rx_avail, tx_dreq, tx_panic, rx_dreq, rx_panic, irq};
  endfunction

  task automatic chk(logic act_v, logic exp_v, string req);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b (tx=%0d rx=%0d ctrl=%h)",
               req, act_v, exp_v, tx_lvl, rx_lvl, ctrl);
    end
  endtask

  task automatic apply(int t, int r, logic a, logic d, logic de, logic ir, logic id, logic [31:0] c);
    @(negedge clk);
    tx_lvl = 7'(t); rx_lvl = 7'(r); act = a; done = d; dma = de;
    ie_rx = ir; ie_done = id; ctrl = c;
    exp_q.push_back(model());
  endtask

  // monitor: result of the previous negedge drive is visible after this edge
  always @(posedge clk) begin
    #5;
    if (exp_q.size() != 0) begin
      logic [8:0] e, o;
      e = exp_q.pop_front();
      o = outs();
      for (int b = 0; b < 9; b++) chk(o[b], e[b], req_of(b));
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R9: reset values
    #35;
    chk(tx_room, 1'b1, "R9 reset tx_room");
    chk(|{rx_full, rx_need, rx_avail, tx_dreq, tx_panic, rx_dreq, rx_panic, irq}, 1'b0,
        "R9 reset others");
    @(negedge clk); rst_n = 1'b1;

    // default thresholds, sweep levels both ways (R1 R2 R3 R4 R5 R6 R7)
    for (int l = 0; l <= 64; l++) apply(l, 64 - l, 1, 0, 1, 0, 0, 32'h3020_1020);
    // extreme thresholds: TX always, RX never; then zero thresholds
    for (int l = 0; l <= 64; l += 4) apply(l, l, 1, 0, 1, 0, 0, 32'hFFFF_FFFF);
    for (int l = 0; l <= 64; l += 4) apply(l, l, 1, 0, 1, 0, 0, 32'h0000_0000);
    for (int l = 0; l <= 64; l++) apply(l, l, 1, 0, 1, 0, 0, 32'h2A05_3F01);

    // R3 drain at end of transfer
    apply(0, 5, 1, 1, 1, 0, 0, 32'h3020_1020);
    apply(0, 0, 1, 1, 1, 0, 0, 32'h3020_1020);
    apply(0, 1, 0, 1, 1, 0, 0, 32'h3020_1020);

    // R10 DMA off
    apply(0, 64, 1, 1, 0, 0, 0, 32'h3020_1020);
    apply(5, 40, 1, 0, 0, 0, 0, 32'h0000_FFFF);

    // R5 inactive forces need_read low; R8 interrupt combinations
    apply(0, 50, 0, 0, 1, 1, 0, 32'h3020_1020);
    apply(0, 47, 1, 0, 1, 1, 0, 32'h3020_1020);
    apply(0, 48, 1, 0, 1, 1, 0, 32'h3020_1020);
    apply(0, 48, 1, 0, 1, 0, 1, 32'h3020_1020);
    apply(0, 10, 1, 1, 1, 0, 1, 32'h3020_1020);
    apply(0, 10, 1, 1, 1, 1, 0, 32'h3020_1020);
    apply(0, 60, 1, 1, 1, 1, 1, 32'h3020_1020);

    // R9 latency: change before the edge is not yet visible
    apply(0, 0, 1, 0, 1, 0, 0, 32'h3020_1020);
    apply(64, 64, 1, 0, 1, 0, 0, 32'h3020_1020);
    #2;
    chk(tx_room, 1'b1, "R9 tx_room before edge");
    chk(rx_avail, 1'b0, "R9 rx_avail before edge");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule